// File: doc/BRIEF.md
# Run-Length Bit Stream Expander

This block turns a stream of compressed code bytes into a serial bit stream for a configuration loader. After reset it first sends a fixed 16-bit prefix. After that it accepts one code byte at a time and expands it into a run of ones and/or zeros, following a fixed four-range table.

The input is a byte stream with valid/ready handshaking, and the output is a one-bit stream with valid/ready handshaking. The output may be stalled at any bit. While stalled it keeps its bit steady, and it never drops or repeats a bit.

An end-of-stream marker can travel with an input byte. It comes out with the final bit of that byte's expansion.

Top module: `rle_bit_expander`

## Requirements
- R1: While reset is held and on the first cycle after it, `in_ready_o` is 0, `out_valid_o` is 1, and `out_bit_o` is 1. That 1 is the first prefix bit.
- R2: Before any code byte is accepted, the output carries the 16 bits 1111_1111_0010_0000, most significant bit first. `in_ready_o` stays 0 until all 16 of these bits have been accepted.
- R3: A code byte n with 1 ≤ n ≤ 226 expands to n ones followed by one zero.
- R4: Code byte 227 expands to 226 ones with no zero after them.
- R5: A code byte n with 228 ≤ n ≤ 254 expands to (n − 228) zeros followed by one one. So code 228 gives a single one.
- R6: Code byte 255 expands to a single one.
- R7: Code byte 0 is consumed and produces no output bits. The next byte's expansion follows it with nothing in between.
- R8: When `out_valid_o` is 1 and `out_ready_o` is 0, the next cycle still has `out_valid_o` at 1, with `out_bit_o` and `out_last_o` unchanged. No bit is lost or repeated under any pattern of stalls.
- R9: `out_last_o` is 1 only on the final bit of the expansion of a byte accepted with `in_last_i` set. A last marker on code byte 0 is dropped.
- R10: A new byte is accepted only when no bit of the previous expansion is still pending. `in_ready_o` and `out_valid_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Code byte valid |
| in_ready_o | output | 1 | Block can take a code byte |
| in_data_i | input | 8 | Code byte |
| in_last_i | input | 1 | End-of-stream marker for this byte |
| out_valid_o | output | 1 | Output bit valid |
| out_ready_o | input | 1 | Consumer takes the bit |
| out_bit_o | output | 1 | Serial output bit |
| out_last_o | output | 1 | Final bit of a marked byte |

## Verification
The bench sweeps every code value from 0 to 255 and then a mixed tail of boundary codes, while a pseudo-random ready pattern with long stalls throttles the output. The boundary codes are 226, 227, 228, 254, 255 and 0 placed between others.

Each boundary catches a specific fault:
- An off-by-one at the 226/227/228 edges shows up as one extra or missing bit.
- A design that emits the trailing zero for 227 inserts a stray 0.
- A design that treats 228 as one zero before the one shifts the whole stream.
- A design that lets code 0 emit a bit or take a cycle of output corrupts the bits that follow.
- Stalls catch a bit that changes or advances while it is not accepted.
- Last markers on several bytes, one of them on code 0, catch a marker placed on the wrong bit or leaked from a dropped byte.

// File: rtl/rle_exp_pkg.sv
package rle_exp_pkg;
  localparam int CODE_W = 8;

  typedef logic [CODE_W-1:0] code_t;

  // One decoded code: a run of run_bit, then an optional terminating bit
  typedef struct packed {
    code_t run_len;
    logic  run_bit;
    logic  has_term;
    logic  term_bit;
  } expand_t;
endpackage

// File: rtl/rle_code_decode.sv
module rle_code_decode
  import rle_exp_pkg::*;
#(
  parameter int MAX_ONES = 226
) (
  input  code_t   code_i,
  output expand_t dec_o
);
  localparam code_t ONES_MAX = code_t'(MAX_ONES);
  localparam code_t ONES_CAP = code_t'(MAX_ONES + 1);
  localparam code_t ZERO_BAS = code_t'(MAX_ONES + 2);
  localparam code_t CODE_TOP = '1;

  always_comb begin
    dec_o = '0;
    if (code_i == '0) begin
      dec_o = '0;
    end else if (code_i <= ONES_MAX) begin
      dec_o.run_len  = code_i;
      dec_o.run_bit  = 1'b1;
      dec_o.has_term = 1'b1;
      dec_o.term_bit = 1'b0;
    end else if (code_i == ONES_CAP) begin
      dec_o.run_len  = ONES_MAX;
      dec_o.run_bit  = 1'b1;
      dec_o.has_term = 1'b0;
    end else if (code_i != CODE_TOP) begin
      dec_o.run_len  = code_i - ZERO_BAS;
      dec_o.run_bit  = 1'b0;
      dec_o.has_term = 1'b1;
      dec_o.term_bit = 1'b1;
    end else begin
      dec_o.has_term = 1'b1;
      dec_o.term_bit = 1'b1;
    end
  end
endmodule

// File: rtl/rle_prefix_gen.sv
module rle_prefix_gen #(
  parameter int              PREFIX_W = 16,
  parameter logic [PREFIX_W-1:0] PREFIX = 16'hFF20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic active_o,
  output logic bit_o
);
  localparam int CNT_W = $clog2(PREFIX_W + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(PREFIX_W);

  logic [PREFIX_W-1:0] sh_q;
  logic [CNT_W-1:0]    cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= PREFIX;
      cnt_q <= '0;
    end else if (adv_i && active_o) begin
      sh_q  <= {sh_q[PREFIX_W-2:0], 1'b0};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign active_o = (cnt_q != CNT_END);
  assign bit_o    = sh_q[PREFIX_W-1];

  // R2
  prefix_done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |=> !active_o);
endmodule

// File: rtl/rle_run_engine.sv
module rle_run_engine
  import rle_exp_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    load_i,
  input  expand_t dec_i,
  input  logic    last_i,
  input  logic    adv_i,
  output logic    busy_o,
  output logic    bit_o,
  output logic    last_o
);
  code_t run_cnt_q;
  logic  run_bit_q, term_pend_q, term_bit_q, last_q;
  logic  in_run;

  assign in_run = (run_cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt_q   <= '0;
      run_bit_q   <= 1'b0;
      term_pend_q <= 1'b0;
      term_bit_q  <= 1'b0;
      last_q      <= 1'b0;
    end else if (load_i) begin
      run_cnt_q   <= dec_i.run_len;
      run_bit_q   <= dec_i.run_bit;
      term_pend_q <= dec_i.has_term;
      term_bit_q  <= dec_i.term_bit;
      last_q      <= last_i;
    end else if (adv_i) begin
      if (in_run) run_cnt_q   <= run_cnt_q - 1'b1;
      else        term_pend_q <= 1'b0;
    end
  end

  assign busy_o = in_run || term_pend_q;
  assign bit_o  = in_run ? run_bit_q : term_bit_q;
  // final bit: last run bit with nothing owed, or the owed terminator
  assign last_o = last_q && ((run_cnt_q == code_t'(1) && !term_pend_q) ||
                             (!in_run && term_pend_q));

  // R10
  no_load_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o);
  // R9
  last_ends_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && last_o) |=> !busy_o);
endmodule

// File: rtl/rle_bit_expander.sv
module rle_bit_expander
  import rle_exp_pkg::*;
#(
  parameter int              MAX_ONES = 226,
  parameter int              PREFIX_W = 16,
  parameter logic [PREFIX_W-1:0] PREFIX = 16'hFF20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  output logic        in_ready_o,
  input  logic [7:0]  in_data_i,
  input  logic        in_last_i,
  output logic        out_valid_o,
  input  logic        out_ready_o,
  output logic        out_bit_o,
  output logic        out_last_o
);
  expand_t dec;
  logic    pre_active, pre_bit;
  logic    run_busy, run_bit, run_last;
  logic    load, adv_run;

  rle_code_decode #(.MAX_ONES(MAX_ONES)) u_dec (
    .code_i (in_data_i),
    .dec_o  (dec)
  );

  rle_prefix_gen #(.PREFIX_W(PREFIX_W), .PREFIX(PREFIX)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (out_ready_o),
    .active_o (pre_active),
    .bit_o    (pre_bit)
  );

  assign in_ready_o = !pre_active && !run_busy;
  assign load       = in_valid_i && in_ready_o;
  assign adv_run    = !pre_active && run_busy && out_ready_o;

  rle_run_engine u_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .dec_i  (dec),
    .last_i (in_last_i),
    .adv_i  (adv_run),
    .busy_o (run_busy),
    .bit_o  (run_bit),
    .last_o (run_last)
  );

  assign out_valid_o = pre_active || run_busy;
  assign out_bit_o   = pre_active ? pre_bit : run_bit;
  assign out_last_o  = !pre_active && run_last;

  // R8
  hold_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_o) |=> (out_valid_o && $stable(out_bit_o) && $stable(out_last_o)));
  // R2
  prefix_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_active |-> !in_ready_o);
  // R10
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));
  // R9
  last_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);
endmodule

// File: tb/sim_rle_bit_expander.sv
module sim_rle_bit_expander;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, out_valid, out_bit, out_last;

  int    checks = 0, errors = 0;
  bit    exp_q[$];
  bit    lst_q[$];
  string tag_q[$];
  bit    feed_done = 1'b0;
  bit    finished = 1'b0;

  always #2 clk = ~clk;

  rle_bit_expander u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data), .in_last_i(in_last),
    .out_valid_o(out_valid), .out_ready_o(out_ready), .out_bit_o(out_bit), .out_last_o(out_last)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic push_bit(input bit b, input bit l, input string tag);
    exp_q.push_back(b); lst_q.push_back(l); tag_q.push_back(tag);
  endtask

  // Expected expansion computed from the code ranges
  task automatic push_code(input int n, input bit l);
    if (n >= 1 && n <= 226) begin
      for (int k = 0; k < n; k++) push_bit(1'b1, 1'b0, "R3");
      push_bit(1'b0, l, "R3/R9");
    end else if (n == 227) begin
      for (int k = 0; k < 226; k++) push_bit(1'b1, l && (k == 225), "R4/R9");
    end else if (n >= 228 && n <= 254) begin
      for (int k = 0; k < n - 228; k++) push_bit(1'b0, 1'b0, "R5");
      push_bit(1'b1, l, "R5/R9");
    end else if (n == 255) begin
      push_bit(1'b1, l, "R6/R9");
    end
    // n == 0: nothing expected (R7), marker dropped (R9)
  endtask

  task automatic send(input int n, input bit l);
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'(n); in_last = l;
    push_code(n, l);
    forever begin
      #1;
      if (in_ready) begin
        @(posedge clk);
        #1 in_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  // Consumer: random ready, compare every accepted bit in order
  initial begin : consumer
    logic [15:0] lfsr = 16'hACE1;
    bit    pend = 1'b0;
    bit    pbit = 1'b0, plast = 1'b0;
    string t;
    wait (rst_n);
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = (lfsr[2:0] != 3'd0) && !(lfsr[15:12] == 4'hF);
      #1;
      if (pend) begin
        chk("R8 valid held", out_valid, 1);
        chk("R8 bit held", out_bit, pbit);
        chk("R8 last held", out_last, plast);
      end
      if (in_ready) chk("R10 ready while output busy", out_valid, 0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk("R7 unexpected extra bit", 1, 0);
        end else begin
          t = tag_q.pop_front();
          chk(t, out_bit, exp_q.pop_front());
          chk({t, " last"}, out_last, lst_q.pop_front());
        end
      end
      pend  = out_valid && !out_ready;
      pbit  = out_bit;
      plast = out_last;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired pending=%0d exp=0", exp_q.size());
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    #1;
    chk("R1 in_ready in reset", in_ready, 0);
    chk("R1 out_valid in reset", out_valid, 1);
    chk("R1 out_bit in reset", out_bit, 1);
    // Prefix FF20, MSB first
    for (int k = 15; k >= 0; k--) push_bit(((16'hFF20 >> k) & 1) != 0, 1'b0, "R2");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 in_ready after reset", in_ready, 0);
    chk("R1 first bit after reset", out_bit, 1);
    // Full sweep of all codes; markers on a few, including code 0
    for (int n = 0; n < 256; n++) send(n, (n % 37) == 0);
    // Boundary tail
    send(227, 1'b1); send(228, 1'b0); send(0, 1'b0); send(255, 1'b1);
    send(226, 1'b0); send(0, 1'b1); send(254, 1'b1); send(1, 1'b0);
    send(227, 1'b0); send(229, 1'b1);
    feed_done = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    #1;
    chk("R10 idle at end", out_valid, 0);
    chk("R10 ready at end", in_ready, 1);
    chk("R9 no last when idle", out_last, 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule